// File: doc/BRIEF.md
# Register-Mapped SPI Master with Word FIFOs

This block is a serial peripheral interface master that sits on a simple 32-bit register bus. Software writes words into a 16-entry transmit queue, programs clock polarity, clock phase and bit order, and drives the active-low slave-select lines through a register. The shift engine sends queued words back to back on `sclk`/`mosi`. For every word sent it captures one word from `miso` into a 16-entry receive queue. The serial clock rate (`HALF_DIV` system cycles per half period) and the word width (`WORD_W`) are fixed when the block is built.

A hold bit keeps the engine idle, so software can preload the transmit queue and then release the whole burst at once. When the last queued word has finished shifting, the block raises a one-cycle `tx_empty_evt` pulse for the interrupt logic. Queue flags are also brought out as ports.

The engine is a three-state machine. In `S_IDLE` the clock rests at the polarity level. From there it goes to `S_HALF_A` when it is allowed to run and a word is queued; it pops that word as it leaves. `S_HALF_A` is the first half of a bit, and it goes to `S_HALF_B` when the half-period counter ends, sampling `miso` on that move. `S_HALF_B` is the second half of a bit. When its counter ends, it goes back to `S_HALF_A` for the next bit; or, after the last bit, to `S_HALF_A` with a freshly popped word; or to `S_IDLE` while raising the event.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset these values hold: control (offset 0x60) reads 0x100, status (0x64) reads 0x05, `ss_n` is all ones, `sclk` is 0, and `tx_empty_evt` is 0.
- R2: A bus write to 0x68 queues bits [WORD_W-1:0] as one transmit word. Status bit 3 is set when 16 words are queued, and a write while full is dropped.
- R3: No `sclk` edge occurs unless control bit 1 (enable) and bit 2 (master) are set and bit 8 (hold) is clear, even with words queued. Clearing the hold bit shifts all queued words back to back.
- R4: Control bit 3 is clock polarity and sets the idle `sclk` level. With control bit 4 (phase) clear, data is valid before the first edge and is sampled on the leading edge. With phase set, data changes on the leading edge and is sampled on the trailing edge.
- R5: With control bit 9 clear, words are sent and received most significant bit first. With bit 9 set, they are sent and received least significant bit first.
- R6: Each word sent stores one received word in the receive queue. A bus read of 0x6C returns and removes the oldest word. A received word that arrives while the queue holds 16 entries is dropped.
- R7: Status bits are as follows: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full. Bit 4 (mode fault) always reads 0.
- R8: Writing 1 to control bit 5 empties the transmit queue, and writing 1 to bit 6 empties the receive queue. Both bits read back as 0.
- R9: `tx_empty_evt` pulses for exactly one cycle per burst, when the last queued word finishes shifting.
- R10: The slave-select register at 0x70 resets to all ones. With control bit 7 set, `ss_n` equals that register. With bit 7 clear, `ss_n` equals the register only while a word is shifting and is all ones otherwise.
- R11: Every word produces exactly 2*WORD_W `sclk` edges, each half period lasting HALF_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at 0x6C) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| tx_empty_evt | output | 1 | One-cycle end-of-burst event |
| flag_rx_empty | output | 1 | Receive queue empty |
| flag_rx_full | output | 1 | Receive queue full |
| flag_tx_empty | output | 1 | Transmit queue empty |
| flag_tx_full | output | 1 | Transmit queue full |

## Verification
Faults in the state machine or its counters show up at the pins within one word. A stuck half counter or bit counter changes the number of `sclk` edges and shifts the captured bits. A wrong sampling point garbles the received word as soon as it is read back. A queue pointer fault shows up on the next status read, or as a missing or extra word at the end of a burst. A misplaced event pulse shows up as a wrong event count for that burst. The bench sweeps all four clock modes in both bit orders, using a bit-level slave model. It also runs both queues to full and exercises flush, hold, disable and both select modes.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_HALF_A = 2'd1,
        S_HALF_B = 2'd2
    } shift_state_e;

    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_STAT = 8'h64;
    localparam logic [7:0] OFS_TXD  = 8'h68;
    localparam logic [7:0] OFS_RXD  = 8'h6C;
    localparam logic [7:0] OFS_SEL  = 8'h70;

    localparam int CB_EN    = 1;
    localparam int CB_MSTR  = 2;
    localparam int CB_CPOL  = 3;
    localparam int CB_CPHA  = 4;
    localparam int CB_TXCLR = 5;
    localparam int CB_RXCLR = 6;
    localparam int CB_MAN   = 7;
    localparam int CB_HOLD  = 8;
    localparam int CB_LSB   = 9;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr, level;

    assign level = wr_ptr - rd_ptr;
    assign empty = (level == '0);
    assign full  = (level == (AW+1)'(DEPTH));
    assign rdata = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    // R2: a push into a full queue is dropped
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && level == $past(level)));

    // R6: a pop from an empty queue changes nothing
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);

    // R8: a flush leaves the queue empty
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              have_data,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              pop_tx,
    output logic              push_rx,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done_evt
);
    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    shift_state_e      state, state_nx;
    logic [HW-1:0]     half_cnt;
    logic [BW-1:0]     bit_idx, pos;
    logic [WORD_W-1:0] cur_word;
    logic              half_last, bit_last, word_end, take;

    assign half_last = (half_cnt == HW'(HALF_DIV - 1));
    assign bit_last  = (bit_idx == BW'(WORD_W - 1));
    assign word_end  = (state == S_HALF_B) && half_last && bit_last;
    assign take      = ((state == S_IDLE) || word_end) && start_ok && have_data;
    assign pos       = lsb_first ? bit_idx : (BW'(WORD_W - 1) - bit_idx);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (take) state_nx = S_HALF_A;
            S_HALF_A: if (half_last) state_nx = S_HALF_B;
            S_HALF_B: if (half_last) state_nx = (!bit_last || take) ? S_HALF_A : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            half_cnt <= '0;
            bit_idx  <= '0;
            cur_word <= '0;
            rx_word  <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                cur_word <= tx_word;
                bit_idx  <= '0;
                half_cnt <= '0;
            end else if (state != S_IDLE) begin
                half_cnt <= half_last ? '0 : half_cnt + 1'b1;
                if (state == S_HALF_B && half_last)
                    bit_idx <= bit_last ? '0 : bit_idx + 1'b1;
            end
            if (state == S_HALF_A && half_last) rx_word[pos] <= miso;
        end
    end

    always_comb begin
        unique case (state)
            S_HALF_A: sclk = cpol ^ cpha;
            S_HALF_B: sclk = ~(cpol ^ cpha);
            default:  sclk = cpol;
        endcase
        mosi     = (state == S_IDLE) ? 1'b0 : cur_word[pos];
        busy     = (state != S_IDLE);
        pop_tx   = take;
        push_rx  = word_end;
        done_evt = word_end && !take;
    end

    // R3: the engine stays idle while it is not allowed to run
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start_ok) |=> (state == S_IDLE));

    // R9: the end-of-burst event is followed by an idle engine
    assert_evt_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (!busy && !done_evt));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int DEPTH    = 16,
    parameter int HALF_DIV = 2,
    parameter int NUM_SS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              tx_empty_evt,
    output logic              flag_rx_empty,
    output logic              flag_rx_full,
    output logic              flag_tx_empty,
    output logic              flag_tx_full
);
    logic              c_en, c_mstr, c_cpol, c_cpha, c_man, c_hold, c_lsb;
    logic [NUM_SS-1:0] sel_reg;
    logic              wr_ctrl, tx_clr, rx_clr, tx_push, rx_pop;
    logic              pop_tx, push_rx, busy, start_ok;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;

    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign tx_clr   = wr_ctrl && bus_wdata[CB_TXCLR];
    assign rx_clr   = wr_ctrl && bus_wdata[CB_RXCLR];
    assign tx_push  = bus_wr && (bus_addr == OFS_TXD);
    assign rx_pop   = bus_rd && (bus_addr == OFS_RXD);
    assign start_ok = c_en && c_mstr && !c_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {c_en, c_mstr, c_cpol, c_cpha, c_man, c_lsb} <= '0;
            c_hold  <= 1'b1;
            sel_reg <= '1;
        end else begin
            if (wr_ctrl) begin
                c_en   <= bus_wdata[CB_EN];
                c_mstr <= bus_wdata[CB_MSTR];
                c_cpol <= bus_wdata[CB_CPOL];
                c_cpha <= bus_wdata[CB_CPHA];
                c_man  <= bus_wdata[CB_MAN];
                c_hold <= bus_wdata[CB_HOLD];
                c_lsb  <= bus_wdata[CB_LSB];
            end
            if (bus_wr && bus_addr == OFS_SEL) sel_reg <= bus_wdata[NUM_SS-1:0];
        end
    end

    spim_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_clr), .push(tx_push),
        .wdata(bus_wdata[WORD_W-1:0]), .pop(pop_tx), .rdata(tx_head),
        .empty(flag_tx_empty), .full(flag_tx_full));

    spim_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_clr), .push(push_rx),
        .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
        .empty(flag_rx_empty), .full(flag_rx_full));

    spim_shifter #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .have_data(!flag_tx_empty),
        .tx_word(tx_head), .cpol(c_cpol), .cpha(c_cpha), .lsb_first(c_lsb),
        .miso(miso), .pop_tx(pop_tx), .push_rx(push_rx), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .busy(busy), .done_evt(tx_empty_evt));

    assign ss_n = (c_man || busy) ? sel_reg : '1;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CB_EN]   = c_en;
                bus_rdata[CB_MSTR] = c_mstr;
                bus_rdata[CB_CPOL] = c_cpol;
                bus_rdata[CB_CPHA] = c_cpha;
                bus_rdata[CB_MAN]  = c_man;
                bus_rdata[CB_HOLD] = c_hold;
                bus_rdata[CB_LSB]  = c_lsb;
            end
            OFS_STAT: bus_rdata[3:0] = {flag_tx_full, flag_tx_empty, flag_rx_full, flag_rx_empty};
            OFS_RXD:  if (!flag_rx_empty) bus_rdata[WORD_W-1:0] = rx_head;
            OFS_SEL:  bus_rdata[NUM_SS-1:0] = sel_reg;
            default:  bus_rdata = '0;
        endcase
    end

    // R10: with automatic select, an idle engine deselects all slaves
    assert_ss_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !c_man && !wr_ctrl) |-> (ss_n == '1));

    // R9: the end event is only raised when the transmit queue is empty or the engine is held
    assert_evt_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |-> (flag_tx_empty || !start_ok));
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    localparam int W = 8;
    localparam int EN = 2, MS = 4, CPOL = 8, CPHA = 16, TXC = 32, RXC = 64;
    localparam int MAN = 128, HOLD = 256, LSB = 512;

    logic        clk = 0, rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        sclk, mosi, miso, tx_empty_evt;
    logic [3:0]  ss_n;
    logic        f_rxe, f_rxf, f_txe, f_txf;

    int total = 0, bad = 0;
    int k = 0, edges = 0, evt_cnt = 0;
    bit mon_en = 0, cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
    logic [W-1:0] cap [64];
    logic [W-1:0] sent [64];

    always #2 clk = ~clk;

    spi_fifo_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
        .ss_n(ss_n), .tx_empty_evt(tx_empty_evt), .flag_rx_empty(f_rxe), .flag_rx_full(f_rxf),
        .flag_tx_empty(f_txe), .flag_tx_full(f_txf));

    function automatic logic [W-1:0] slv_word(int n);
        return W'((n * 37 + 91) & 255);
    endfunction

    function automatic int bpos(int i);
        return cur_lsb ? i : (W - 1 - i);
    endfunction

    assign miso = slv_word(k / W)[bpos(k % W)];

    always @(sclk) begin
        if (mon_en) begin
            edges++;
            if (sclk == (cur_cpol ^ !cur_cpha)) begin
                cap[(k / W) % 64][bpos(k % W)] = mosi;
                k++;
            end
        end
    end

    always @(negedge clk) if (rst_n && tx_empty_evt) evt_cnt++;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, int d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output int d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(int ctl);
        mon_en = 0;
        wr(8'h60, ctl);
        cur_cpol = ctl[3]; cur_cpha = ctl[4]; cur_lsb = ctl[9];
        idle(3);
        k = 0; edges = 0; evt_cnt = 0; mon_en = 1;
    endtask

    task automatic burst(int mode, int seed, int n);
        int base, d;
        base = EN | MS | MAN | mode;
        set_mode(base | HOLD);
        check("R4 idle sclk level", sclk, cur_cpol);
        for (int t = 0; t < n; t++) begin
            sent[t] = W'((t * 53 + 17 + seed * 11) & 255);
            wr(8'h68, sent[t]);
        end
        idle(20);
        check("R3 no edges while held", edges, 0);
        wr(8'h60, base);
        idle(n * W * 4 + 20);
        check("R11 edge count", edges, 2 * W * n);
        check("R9 one event", evt_cnt, 1);
        for (int t = 0; t < n; t++) check("R5 R4 word sent", cap[t], sent[t]);
        for (int t = 0; t < n; t++) begin
            rd(8'h6C, d);
            check("R6 word received", d, slv_word(t));
        end
        rd(8'h64, d);
        check("R7 status after burst", d, 5);
        wr(8'h60, base | HOLD);
    endtask

    initial begin
        #150000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d;
        idle(3);
        #1;
        check("R1 sclk", sclk, 0);
        check("R1 ss_n", ss_n, 4'hF);
        check("R1 event", tx_empty_evt, 0);
        rst_n = 1;
        rd(8'h60, d); check("R1 control", d, 32'h100);
        rd(8'h64, d); check("R1 status", d, 5);
        rd(8'h70, d); check("R10 select reset", d, 4'hF);

        wr(8'h70, 4'hE);
        wr(8'h60, EN | MS | MAN | HOLD);
        idle(1);
        check("R10 manual select", ss_n, 4'hE);

        // sweep: 4 clock modes x 2 bit orders
        for (int m = 0; m < 8; m++)
            burst((m[0] ? CPOL : 0) | (m[1] ? CPHA : 0) | (m[2] ? LSB : 0), m, 3);

        // transmit queue full, receive queue full with drop
        set_mode(EN | MS | MAN | HOLD);
        for (int t = 0; t < 17; t++) begin
            sent[t] = W'(t * 29 + 3);
            wr(8'h68, sent[t]);
        end
        rd(8'h64, d); check("R2 R7 tx full status", d, 32'h09);
        wr(8'h60, EN | MS | MAN);
        idle(16 * W * 4 + 30);
        check("R2 dropped 17th word", edges, 2 * W * 16);
        for (int t = 0; t < 16; t++) check("R2 word order", cap[t], sent[t]);
        rd(8'h64, d); check("R7 rx full status", d, 32'h06);
        wr(8'h68, 8'hA5);
        idle(W * 4 + 20);
        check("R2 later word sent", cap[16], 8'hA5);
        check("R9 two bursts two events", evt_cnt, 2);
        for (int t = 0; t < 16; t++) begin
            rd(8'h6C, d);
            check("R6 full queue keeps oldest", d, slv_word(t));
        end
        rd(8'h64, d); check("R6 R7 rx drained", d, 5);

        // flush transmit queue
        set_mode(EN | MS | MAN | HOLD);
        wr(8'h68, 8'h11); wr(8'h68, 8'h22);
        wr(8'h60, EN | MS | MAN | HOLD | TXC);
        rd(8'h64, d); check("R8 tx flushed", d, 5);
        rd(8'h60, d); check("R8 flush bits read 0", d, EN | MS | MAN | HOLD);
        wr(8'h60, EN | MS | MAN);
        idle(40);
        check("R8 nothing shifted after flush", edges, 0);

        // flush receive queue
        wr(8'h68, 8'h33); wr(8'h68, 8'h44);
        idle(2 * W * 4 + 20);
        rd(8'h64, d); check("R6 rx holds words", d, 4);
        wr(8'h60, EN | MS | MAN | RXC);
        rd(8'h64, d); check("R8 rx flushed", d, 5);

        // automatic select
        set_mode(EN | MS | HOLD);
        wr(8'h70, 4'hD);
        idle(1);
        check("R10 auto select idle", ss_n, 4'hF);
        wr(8'h68, 8'h55); wr(8'h68, 8'h66);
        wr(8'h60, EN | MS);
        idle(10);
        check("R10 auto select busy", ss_n, 4'hD);
        idle(2 * W * 4 + 20);
        check("R10 auto select after", ss_n, 4'hF);
        for (int t = 0; t < 2; t++) rd(8'h6C, d);

        // not enabled: queued word must wait
        set_mode(MS);
        wr(8'h68, 8'h77);
        idle(50);
        check("R3 no edges when disabled", edges, 0);
        check("R3 word still queued", f_txe, 0);
        wr(8'h60, EN | MS);
        idle(W * 4 + 20);
        check("R3 shifts once enabled", edges, 2 * W);
        check("R3 word value", cap[0], 8'h77);
        rd(8'h6C, d);
        check("R6 received after enable", d, slv_word(0));
        rd(8'h64, d); check("R7 fault bit zero", d[4], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule